// File: doc/BRIEF.md
# Asynchronous Memory Write Sequencer

This block turns a single-cycle write request from the system clock domain into a complete write cycle on an external asynchronous memory or peripheral bus. It drives a bank's chip select, the address, the data and an active-low write strobe. Two counts are taken from plain configuration inputs when a request is accepted: a wait-state count that sets the strobe length, and a hold-cycle count that sets how long address, select and data stay on the bus after the strobe ends. A target can hold an acknowledge input low to stretch the strobe. That input is brought into the clock domain through a two-flop synchronizer.

The sequencer also spaces accesses apart. After a write finishes, a following write is issued only after the write-to-write recovery time. A following read is given a one-cycle start pulse, which tells a separate read path that its strobe may fall in that cycle. The pulse comes only once the longer write-to-read recovery has passed, and only after the write data drive has been off the bus for at least two cycles. Read data capture belongs to that read path and is not part of this block.

Top module: `amw_write_seq`

## Requirements
- R1: After reset, busy is 0, the write strobe is high (1), every chip select is high (inactive), the data drive enable is 0 and the read start pulse is 0.
- R2: On the clock edge that accepts a write, the address, the data and the data drive enable become valid. The chip select selected by the bank index goes low, and it is the only one low (bank n drives bit n of the select bus low). The write strobe falls on the next edge, one cycle later.
- R3: With acknowledge high, the write strobe stays low for exactly W cycles, where W is the sampled wait count. A wait count of 0 is treated as 1.
- R4: Address, chip select and data stay constant and driven while the strobe is low. They are held for exactly H cycles after the strobe rises, where H is the sampled hold count. On the edge after that, the select goes high and the data drive enable drops to 0 together (for H = 0, on the edge where the strobe rises).
- R5: Acknowledge is synchronized through two flops and only looked at once the wait count has run out. If acknowledge returns high in the cycle after edge X, the strobe rises at edge max(accept+1+W, X+3).
- R6: When a write request is presented as soon as the previous write ends, the next write strobe falls exactly H+2 cycles after the previous strobe rose, which meets the minimum of H+1. The bank does not affect this.
- R7: When a read request follows a write, the read start pulse comes no earlier than H+3 cycles after the write strobe rose. The data drive enable is 0 for at least the two cycles before the pulse. If the read is presented as soon as the write ends, the pulse comes at exactly H+3.
- R8: A read request with no recovery pending gives a read start pulse one cycle after it is accepted. The pulse is always exactly one cycle wide.
- R9: Busy is high from the accepting edge until the write's hold phase ends, or until the read start pulse for a read. A request presented while busy is high is ignored: it changes no bus output and starts no later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when busy is low |
| req_read | input | 1 | 1 = read request (recovery timing only), 0 = write |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_bank | input | BW | Bank index, selects one chip select |
| cfg_wait | input | CW | Wait-state count W, sampled on accept |
| cfg_hold | input | CW | Hold-cycle count H, sampled on accept |
| mem_ack | input | 1 | Asynchronous acknowledge; low stretches the strobe |
| busy | output | 1 | Sequencer occupied; requests ignored |
| rd_go | output | 1 | One-cycle pulse: read strobe may fall this cycle |
| mem_addr | output | AW | Bus address |
| mem_cs_n | output | NBANK | Active-low chip selects, one per bank |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_o | output | DW | Write data toward the bus |
| mem_dq_oe | output | 1 | Data drive enable; 0 means released (high impedance) |

## Verification
The assertions assume that the bank index is always below the bank count. They also assume that a request is only counted as accepted when busy is low and req_valid is high on the same edge. Their strobe-length check depends on the wait count seen at that accepting edge. The bench keeps to these assumptions: it uses only the four legal bank indices, and it changes request and configuration inputs only on falling clock edges. Acknowledge is lowered before a request and raised on a falling edge, so its synchronizer delay is known to the cycle.

// File: rtl/amw_pkg.sv
package amw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_RWAIT  = 3'd4
    } amw_state_e;

    // Extra cycles, beyond the hold phase, that a read must wait after a write.
    localparam int RD_GAP_CYC = 2;
    localparam int GAP_W      = 2;
    // Synchronizer depth for the acknowledge input.
    localparam int ACK_STAGES = 2;

endpackage

// File: rtl/amw_ack_sync.sv
module amw_ack_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= async_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/amw_bank_decode.sv
module amw_bank_decode #(
    parameter int NBANK = 4,
    parameter int BW    = 2
) (
    input  logic             act,
    input  logic [BW-1:0]    bank,
    output logic [NBANK-1:0] cs_n
);

    generate
        for (genvar i = 0; i < NBANK; i++) begin : g_sel
            assign cs_n[i] = ~(act && (bank == BW'(i)));
        end
    endgenerate

endmodule

// File: rtl/amw_write_seq.sv
module amw_write_seq
    import amw_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int NBANK = 4,
    parameter int CW    = 4,
    localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_read,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_data,
    input  logic [BW-1:0]    req_bank,
    input  logic [CW-1:0]    cfg_wait,
    input  logic [CW-1:0]    cfg_hold,
    input  logic             mem_ack,
    output logic             busy,
    output logic             rd_go,
    output logic [AW-1:0]    mem_addr,
    output logic [NBANK-1:0] mem_cs_n,
    output logic             mem_we_n,
    output logic [DW-1:0]    mem_dq_o,
    output logic             mem_dq_oe
);

    typedef struct packed {
        amw_state_e       st;
        logic [CW-1:0]    cnt;
        logic [CW-1:0]    hold;
        logic [GAP_W-1:0] gap;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
        logic [BW-1:0]    bank;
        logic             act;
        logic             oe;
        logic             we_n;
        logic             rd_go;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st:    ST_IDLE,
        cnt:   '0,
        hold:  '0,
        gap:   '0,
        addr:  '0,
        data:  '0,
        bank:  '0,
        act:   1'b0,
        oe:    1'b0,
        we_n:  1'b1,
        rd_go: 1'b0
    };

    seq_t s_d, s_q;
    logic ack_s;
    logic release_bus;

    amw_ack_sync #(
        .STAGES  (ACK_STAGES),
        .RST_VAL (1'b1)
    ) u_ack_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (mem_ack),
        .sync_o  (ack_s)
    );

    amw_bank_decode #(
        .NBANK (NBANK),
        .BW    (BW)
    ) u_bank_decode (
        .act   (s_q.act),
        .bank  (s_q.bank),
        .cs_n  (mem_cs_n)
    );

    always_comb begin
        s_d         = s_q;
        s_d.rd_go   = 1'b0;
        release_bus = 1'b0;

        if (s_q.gap != '0) begin
            s_d.gap = s_q.gap - 1'b1;
        end

        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_read) begin
                        s_d.st = ST_RWAIT;
                    end else begin
                        s_d.st   = ST_SETUP;
                        s_d.addr = req_addr;
                        s_d.data = req_data;
                        s_d.bank = req_bank;
                        s_d.act  = 1'b1;
                        s_d.oe   = 1'b1;
                        s_d.hold = cfg_hold;
                        s_d.cnt  = (cfg_wait == '0) ? '0 : (cfg_wait - 1'b1);
                    end
                end
            end

            ST_SETUP: begin
                s_d.we_n = 1'b0;
                s_d.st   = ST_STROBE;
            end

            ST_STROBE: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (ack_s) begin
                    s_d.we_n = 1'b1;
                    if (s_q.hold == '0) begin
                        release_bus = 1'b1;
                    end else begin
                        s_d.st  = ST_HOLD;
                        s_d.cnt = s_q.hold - 1'b1;
                    end
                end
            end

            ST_HOLD: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    release_bus = 1'b1;
                end
            end

            ST_RWAIT: begin
                if (s_q.gap == '0) begin
                    s_d.rd_go = 1'b1;
                    s_d.st    = ST_IDLE;
                end
            end

            default: begin
                s_d = SEQ_RST;
            end
        endcase

        if (release_bus) begin
            s_d.act = 1'b0;
            s_d.oe  = 1'b0;
            s_d.gap = GAP_W'(RD_GAP_CYC);
            s_d.st  = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign rd_go     = s_q.rd_go;
    assign mem_addr  = s_q.addr;
    assign mem_we_n  = s_q.we_n;
    assign mem_dq_o  = s_q.data;
    assign mem_dq_oe = s_q.oe;

endmodule

// File: rtl/amw_write_seq_chk.sv
module amw_write_seq_chk #(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int NBANK = 4,
    parameter int CW    = 4,
    parameter int BW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_read,
    input logic [CW-1:0]    cfg_wait,
    input logic             busy,
    input logic             rd_go,
    input logic [AW-1:0]    mem_addr,
    input logic [NBANK-1:0] mem_cs_n,
    input logic             mem_we_n,
    input logic [DW-1:0]    mem_dq_o,
    input logic             mem_dq_oe
);

    localparam int LW = CW + 8;

    logic [LW-1:0] lo_cnt_q;
    logic [CW-1:0] w_min_q;
    logic          cs_any;

    assign cs_any = (mem_cs_n != {NBANK{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt_q <= '0;
            w_min_q  <= '0;
        end else begin
            if (!mem_we_n) begin
                if (lo_cnt_q != {LW{1'b1}}) lo_cnt_q <= lo_cnt_q + 1'b1;
            end else begin
                lo_cnt_q <= '0;
            end
            if (req_valid && !busy && !req_read) begin
                w_min_q <= (cfg_wait == '0) ? CW'(1) : cfg_wait;
            end
        end
    end

    p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    p_setup_before_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(cs_any) && $past(mem_dq_oe)));

    p_strobe_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (lo_cnt_q >= LW'(w_min_q)));

    p_strobe_covered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe && cs_any));

    p_bus_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_any && $past(cs_any)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

    p_read_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |-> (!mem_dq_oe && !$past(mem_dq_oe) && !$past(mem_dq_oe, 2)));

    p_rd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> !rd_go);

    p_busy_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe || !mem_we_n) |-> busy);

endmodule

bind amw_write_seq amw_write_seq_chk #(
    .AW    (AW),
    .DW    (DW),
    .NBANK (NBANK),
    .CW    (CW),
    .BW    (BW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_read  (req_read),
    .cfg_wait  (cfg_wait),
    .busy      (busy),
    .rd_go     (rd_go),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/amw_write_seq_test.sv
module amw_write_seq_test;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int NB = 4;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_read = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [1:0]    req_bank = '0;
    logic [CW-1:0] cfg_wait = '0;
    logic [CW-1:0] cfg_hold = '0;
    logic          mem_ack = 1'b1;
    logic          busy;
    logic          rd_go;
    logic [AW-1:0] mem_addr;
    logic [NB-1:0] mem_cs_n;
    logic          mem_we_n;
    logic [DW-1:0] mem_dq_o;
    logic          mem_dq_oe;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int last_rise = 0;
    int last_h = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    amw_write_seq #(.AW(AW), .DW(DW), .NBANK(NB), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_addr(req_addr), .req_data(req_data), .req_bank(req_bank),
        .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .mem_ack(mem_ack),
        .busy(busy), .rd_go(rd_go), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1", "busy", int'(busy), 0);
        check("R1", "we_n", int'(mem_we_n), 1);
        check("R1", "cs_n", int'(mem_cs_n), 15);
        check("R1", "oe", int'(mem_dq_oe), 0);
        check("R1", "rd_go", int'(rd_go), 0);
    endtask

    // Issues one write at the current falling edge and follows it to completion.
    task automatic run_write(input logic [15:0] a, input logic [15:0] d, input int b,
                             input int w, input int h, input int ack_at,
                             input bit chained, input bit poke);
        int k, fall, rise, rel, bad, weff, exp_rise;
        fall = -1; rise = -1; rel = -1; bad = 0;
        weff = (w == 0) ? 1 : w;
        if (ack_at >= 0) mem_ack = 1'b0;
        req_valid = 1'b1; req_read = 1'b0; req_addr = a; req_data = d;
        req_bank = 2'(b); cfg_wait = CW'(w); cfg_hold = CW'(h);
        @(posedge clk);
        @(negedge clk);
        k = cyc;
        req_valid = 1'b0;
        cfg_wait = 4'hF; cfg_hold = 4'hF;
        check("R2", "addr at accept", int'(mem_addr), int'(a));
        check("R2", "data at accept", int'(mem_dq_o), int'(d));
        check("R2", "cs_n at accept", int'(mem_cs_n), int'(~(4'b0001 << b) & 4'hF));
        check("R2", "oe at accept", int'(mem_dq_oe), 1);
        check("R2", "we_n before strobe", int'(mem_we_n), 1);
        check("R9", "busy at accept", int'(busy), 1);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (poke && i == 0) begin
                req_valid = 1'b1; req_addr = ~a; req_data = ~d; req_bank = 2'(b + 1);
            end
            if (poke && i == 1) req_valid = 1'b0;
            if (ack_at >= 0 && cyc == k + ack_at) mem_ack = 1'b1;
            if (fall < 0 && !mem_we_n) fall = cyc;
            if (fall >= 0 && rise < 0 && mem_we_n) rise = cyc;
            if (rise >= 0 && rel < 0 && !mem_dq_oe) rel = cyc;
            if (mem_cs_n != 4'hF) begin
                if (mem_addr != a || mem_dq_o != d || !mem_dq_oe) bad++;
            end
            if (!busy) break;
        end
        exp_rise = k + 1 + weff;
        if (ack_at >= 0 && k + ack_at + 3 > exp_rise) exp_rise = k + ack_at + 3;
        check("R2", "strobe fall cycle", fall - k, 1);
        if (ack_at >= 0) check("R5", "strobe rise with ack", rise - k, exp_rise - k);
        else             check("R3", "strobe low cycles", rise - fall, weff);
        check("R4", "hold cycles after rise", rel - rise, h);
        check("R4", "bus changes while selected", bad, 0);
        check("R4", "cs_n after release", int'(mem_cs_n), 15);
        check("R9", "busy drop cycle", cyc - k, rel - k);
        if (chained) check("R6", "write to write gap", fall - last_rise, last_h + 2);
        if (poke) begin
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                check("R9", "ignored request started nothing", int'({busy, mem_we_n, mem_dq_oe}), 2);
            end
        end
        last_rise = rise;
        last_h = h;
        mem_ack = 1'b1;
    endtask

    task automatic run_read(input bit after_write);
        int k, g;
        g = -1;
        req_valid = 1'b1; req_read = 1'b1;
        @(posedge clk);
        @(negedge clk);
        k = cyc;
        req_valid = 1'b0; req_read = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (rd_go) begin
                g = cyc;
                check("R7", "drive released at read start", int'(mem_dq_oe), 0);
                check("R9", "busy low at read start", int'(busy), 0);
                break;
            end
            @(negedge clk);
        end
        if (after_write) check("R7", "write to read start", g - last_rise, last_h + 3);
        else             check("R8", "read start after accept", g - k, 1);
        @(negedge clk);
        check("R8", "read pulse width", int'(rd_go), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_write(16'h1234, 16'hA5C3, 1, 3, 2, -1, 1'b0, 1'b0);
        run_write(16'h00F0, 16'h5A5A, 3, 0, 0, -1, 1'b1, 1'b0);
        run_write(16'hBEEF, 16'h0F0F, 0, 2, 1,  5, 1'b1, 1'b0);
        run_write(16'h7777, 16'h1111, 2, 4, 0,  1, 1'b1, 1'b0);
        run_read(1'b1);
        repeat (5) @(negedge clk);
        run_read(1'b0);
        run_write(16'h2468, 16'hCAFE, 2, 2, 3, -1, 1'b0, 1'b1);
        run_write(16'h1357, 16'h8001, 1, 1, 4, -1, 1'b0, 1'b0);
        run_read(1'b1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule